// File: doc/BRIEF.md
# Lookup-Table Distributed RAM

This block is a small memory whose storage bits are lookup-table cells. Reading works exactly like evaluating a lookup table: the read address drives the select lines of a multiplexer tree over the stored bits, so data out follows the read address with no clock involved. Writing uses a separate path. A decoder, enabled only when the write enable is high, turns the write address into a one-hot set of strobes. On the rising clock edge, the single storage word picked by those strobes takes the input data.

Each cell holds 2^CELL_AW words. CELLS cells are placed side by side to give a deeper memory, with at most 64 words in total. The address bits above the cell field choose which cell receives the write strobe and which cell's output reaches the data port. With DUAL_PORT=1 the block is a simple dual-port memory: one write port, plus a separate read address. With DUAL_PORT=0 it is single-port: reads use the write address, and the read-address pin is not used. The storage comes up as all zeros.

Top module: `lut_dist_ram`

## Requirements
- R1: When `we` is 1 at a rising edge of `clk`, the word at `waddr` holds `din` from that edge onward.
- R2: A rising edge with `we` at 0 changes no stored word, whatever `waddr` and `din` carry.
- R3: A write changes only the addressed word. A word at any other address keeps its value.
- R4: `dout` is combinational from the read address. It shows the addressed word in the same cycle the address is applied, with no clock edge needed.
- R5: Reading the address being written in the current cycle returns the old contents until the clock edge. After the edge it returns the new data.
- R6: The address bits above the low CELL_AW bits select the cell. Addresses that differ only in those upper bits (for example 3 and 35 with CELL_AW=5) are separate words.
- R7: With DUAL_PORT=0, `dout` shows the word at `waddr`, and `raddr` has no effect on `dout`.
- R8: Every one of the CELLS*2^CELL_AW words (64 by default) stores its own value.
- R9: Before any write, every word reads as zero, and `dout` is never unknown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock; writes occur on its rising edge |
| we | input | 1 | Write enable; enables the write strobe decoder |
| waddr | input | ADDR_W | Write address; also the read address in single-port mode |
| din | input | WIDTH | Write data |
| raddr | input | ADDR_W | Read address (dual-port mode only) |
| dout | output | WIDTH | Combinational read data |

## Verification
The bench reads the address being written in the same cycle and checks that the old word comes back. A design that wrote through, or that registered the read, would return the new word or a stale one. It writes to addresses that differ only in the cell-select bits, and to neighbouring addresses. A decoder that ignored the upper bits, or strobed more than one word, would corrupt the other location. It also repeats cycles with the enable low but changing data, which would catch a write path that ignores `we`. A second instance in single-port mode is driven with a read address that differs from the write address. If the port choice were wrong, that instance would follow `raddr` instead of `waddr`.

// File: rtl/lutram_pkg.sv
package lutram_pkg;

  // Number of address bits that pick a cell; zero for a single cell.
  function automatic int unsigned cell_sel_bits(input int unsigned cells);
    return (cells > 1) ? $clog2(cells) : 0;
  endfunction

  // Width of a select bus that is never zero-wide.
  function automatic int unsigned bus_width(input int unsigned bits);
    return (bits > 0) ? bits : 1;
  endfunction

endpackage

// File: rtl/lutram_wr_decode.sv
module lutram_wr_decode #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DEPTH  = 64
) (
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  output logic [DEPTH-1:0]  strobe
);

  // One strobe per stored word, enabled by the write enable.
  for (genvar i = 0; i < DEPTH; i++) begin : g_dec
    assign strobe[i] = we && (waddr == ADDR_W'(i));
  end

endmodule

// File: rtl/lutram_cell.sv
module lutram_cell #(
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned CELL_AW = 5,
  localparam int unsigned CELL_DEPTH = 1 << CELL_AW
) (
  input  logic                  clk,
  input  logic [CELL_DEPTH-1:0] strobe,
  input  logic [WIDTH-1:0]      din,
  input  logic [CELL_AW-1:0]    raddr,
  output logic [WIDTH-1:0]      rdata
);

  logic [CELL_DEPTH-1:0][WIDTH-1:0] words;

  // Each word is a set of truth-table cells loaded by its own strobe.
  for (genvar i = 0; i < CELL_DEPTH; i++) begin : g_word
    logic [WIDTH-1:0] word_q = '0;
    always_ff @(posedge clk) begin
      if (strobe[i]) word_q <= din;
    end
    assign words[i] = word_q;
  end

  // Read path: the address is the select of the lookup multiplexer.
  assign rdata = words[raddr];

endmodule

// File: rtl/lutram_rd_select.sv
module lutram_rd_select #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned CELLS = 2,
  parameter int unsigned SEL_W = 1
) (
  input  logic [CELLS-1:0][WIDTH-1:0] cell_data,
  input  logic [SEL_W-1:0]            sel,
  output logic [WIDTH-1:0]            dout
);

  if (CELLS == 1) begin : g_single
    logic unused_sel;
    assign unused_sel = ^sel;
    assign dout = cell_data[0];
  end else begin : g_multi
    assign dout = cell_data[sel];
  end

endmodule

// File: rtl/lut_dist_ram.sv
module lut_dist_ram #(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned CELL_AW   = 5,
  parameter int unsigned CELLS     = 2,
  parameter bit          DUAL_PORT = 1'b1,
  localparam int unsigned HI_W       = lutram_pkg::cell_sel_bits(CELLS),
  localparam int unsigned SEL_W      = lutram_pkg::bus_width(HI_W),
  localparam int unsigned ADDR_W     = CELL_AW + HI_W,
  localparam int unsigned CELL_DEPTH = 1 << CELL_AW,
  localparam int unsigned DEPTH      = CELLS * CELL_DEPTH
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  din,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  dout
);

  logic [ADDR_W-1:0]            rd_addr;
  logic [SEL_W-1:0]             rd_sel;
  logic [DEPTH-1:0]             strobe;
  logic [CELLS-1:0][WIDTH-1:0]  cell_data;

  // Port variant: single-port reads at the write address.
  if (DUAL_PORT) begin : g_dual
    assign rd_addr = raddr;
  end else begin : g_sp
    logic unused_raddr;
    assign unused_raddr = ^raddr;
    assign rd_addr = waddr;
  end

  // Upper address bits pick the cell.
  if (CELLS > 1) begin : g_hi
    assign rd_sel = rd_addr[ADDR_W-1:CELL_AW];
  end else begin : g_nohi
    assign rd_sel = '0;
  end

  lutram_wr_decode #(
    .ADDR_W(ADDR_W),
    .DEPTH (DEPTH)
  ) u_dec (
    .we    (we),
    .waddr (waddr),
    .strobe(strobe)
  );

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    lutram_cell #(
      .WIDTH  (WIDTH),
      .CELL_AW(CELL_AW)
    ) u_cell (
      .clk   (clk),
      .strobe(strobe[c*CELL_DEPTH +: CELL_DEPTH]),
      .din   (din),
      .raddr (rd_addr[CELL_AW-1:0]),
      .rdata (cell_data[c])
    );
  end

  lutram_rd_select #(
    .WIDTH(WIDTH),
    .CELLS(CELLS),
    .SEL_W(SEL_W)
  ) u_rsel (
    .cell_data(cell_data),
    .sel      (rd_sel),
    .dout     (dout)
  );

endmodule

// File: rtl/lut_dist_ram_props.sv
module lut_dist_ram_props #(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned ADDR_W    = 6,
  parameter bit          DUAL_PORT = 1'b1
) (
  input logic              clk,
  input logic              we,
  input logic [ADDR_W-1:0] waddr,
  input logic [WIDTH-1:0]  din,
  input logic [ADDR_W-1:0] raddr,
  input logic [WIDTH-1:0]  dout
);

  logic [1:0]        age = 2'd0;
  logic              primed;
  logic [ADDR_W-1:0] eff_raddr;

  always_ff @(posedge clk) begin
    if (age != 2'd2) age <= age + 2'd1;
  end
  assign primed = (age == 2'd2);

  if (DUAL_PORT) begin : g_dp
    assign eff_raddr = raddr;
  end else begin : g_sp
    assign eff_raddr = waddr;
  end

  assert_write_lands_R1: assert property (@(posedge clk) disable iff (!primed)
    ($past(we) && eff_raddr == $past(waddr)) |-> dout == $past(din));

  assert_idle_no_change_R2: assert property (@(posedge clk) disable iff (!primed)
    (!$past(we) && $stable(eff_raddr)) |-> $stable(dout));

  assert_other_word_kept_R3: assert property (@(posedge clk) disable iff (!primed)
    ($past(we) && $past(waddr) != eff_raddr && $stable(eff_raddr)) |-> $stable(dout));

  always @(negedge clk) begin
    if (primed) assert_dout_known_R9: assert (!$isunknown(dout));
  end

endmodule

bind lut_dist_ram lut_dist_ram_props #(
  .WIDTH    (WIDTH),
  .ADDR_W   (ADDR_W),
  .DUAL_PORT(DUAL_PORT)
) u_props (
  .clk  (clk),
  .we   (we),
  .waddr(waddr),
  .din  (din),
  .raddr(raddr),
  .dout (dout)
);

// File: tb/lut_dist_ram_test.sv
module lut_dist_ram_test;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int N  = 64;

  logic          clk = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] waddr = '0;
  logic [DW-1:0] din = '0;
  logic [AW-1:0] raddr = '0;
  logic [DW-1:0] dout, dout_sp;

  logic [DW-1:0] model [N];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  lut_dist_ram #(.WIDTH(DW), .CELL_AW(5), .CELLS(2), .DUAL_PORT(1'b1)) uut (
    .clk(clk), .we(we), .waddr(waddr), .din(din), .raddr(raddr), .dout(dout));

  lut_dist_ram #(.WIDTH(DW), .CELL_AW(5), .CELLS(2), .DUAL_PORT(1'b0)) uut_sp (
    .clk(clk), .we(we), .waddr(waddr), .din(din), .raddr(raddr), .dout(dout_sp));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle; checks both read ports before the edge, updates the model after.
  task automatic step(input string req, input bit w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [AW-1:0] ra);
    @(negedge clk);
    we = w; waddr = a; din = d; raddr = ra;
    #1;
    chk(req, dout, model[ra]);
    chk("R7", dout_sp, model[a]);
    @(posedge clk);
    if (w) model[a] = d;
  endtask

  initial begin
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (2) @(posedge clk);

    // R9: power-up contents are zero
    for (int a = 0; a < N; a++) step("R9", 1'b0, AW'(a), DW'($urandom), AW'(a));

    // R1 and R5: same-cycle read sees old data, next cycle sees new
    step("R5", 1'b1, 6'd10, 8'h5A, 6'd10);
    #1; chk("R5", dout, 8'h5A);
    step("R1", 1'b0, 6'd10, 8'h00, 6'd10);

    // R2: enable low with changing data leaves the word alone
    for (int k = 0; k < 4; k++) step("R2", 1'b0, 6'd10, DW'($urandom), 6'd10);
    chk("R2", dout, 8'h5A);

    // R3: neighbours written, word 10 untouched
    step("R3", 1'b1, 6'd11, 8'hC3, 6'd10);
    step("R3", 1'b1, 6'd9, 8'h3C, 6'd10);
    chk("R3", dout, 8'h5A);

    // R6: addresses 3 and 35 differ only in the cell-select bit
    step("R6", 1'b1, 6'd3, 8'h11, 6'd35);
    step("R6", 1'b1, 6'd35, 8'hEE, 6'd3);
    step("R6", 1'b0, 6'd0, 8'h00, 6'd3);
    chk("R6", dout, 8'h11);
    step("R6", 1'b0, 6'd0, 8'h00, 6'd35);
    chk("R6", dout, 8'hEE);

    // R8: fill every word with a distinct value and read all back
    for (int a = 0; a < N; a++) step("R8", 1'b1, AW'(a), DW'(a) ^ 8'hA5, AW'(N-1-a));
    for (int a = 0; a < N; a++) begin
      step("R8", 1'b0, AW'(a), 8'hFF, AW'(a));
      chk("R8", dout, DW'(a) ^ 8'hA5);
    end

    // R4/R7: random traffic against the array model
    for (int k = 0; k < 2000; k++)
      step("R4", 1'($urandom), AW'($urandom), DW'($urandom), AW'($urandom));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule